// File: doc/BRIEF.md
# Transmit slot reader with completion queue

This block sends Ethernet frames that software has already written into a small set of on-chip transmit slots. Software fills a slot through a byte-wide write port. It then posts a command that names the slot and the frame length in bytes. The reader takes commands one at a time. It fetches the slot bytes through a registered (synchronous) read port and presents them as a valid/ready byte stream, with a last flag on the final byte.

After the final byte of a frame is accepted, the reader writes a completion record into a return queue. The record holds the slot index and the timestamp input value sampled when the first byte of that frame was accepted. The interrupt output is a level that stays high while any record is waiting. Each acknowledge pulse removes the oldest record. With the timestamp option turned off, the queue is replaced by a single pending register, and the timestamp field reads zero.

The slot count is a parameter. Two slots are enough when software uses them alternately, filling one while the other is sent.

Top module: `pktbuf_tx_reader`

## Requirements
- R1: After reset, `tx_valid` is 0, `irq` is 0 and `cmd_ready` is 1.
- R2: A frame for slot s with effective length L streams the bytes at slot offsets 0 to L-1 in ascending order. The byte at offset k is the last value written to address s*SLOT_BYTES+k. A programmed length above SLOT_BYTES is clamped to SLOT_BYTES.
- R3: `tx_last` is 1 on byte L of the frame and 0 on every earlier byte. After the last byte is accepted, `tx_valid` is 0 in the next cycle.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_last` keep their values and `tx_valid` stays 1.
- R5: A programmed length of 0 sends a one-byte frame (offset 0, with `tx_last` set) and produces one completion record.
- R6: Every sent frame produces exactly one completion record. Records come out in command order, and each carries the index of the slot that was sent.
- R7: The timestamp of a record equals the `ts_in` value in the cycle whose rising edge accepted the first byte of that frame.
- R8: `irq` is 1 exactly while at least one record is waiting. It stays 1 after an acknowledge if more records remain, and it falls only after an acknowledge.
- R9: An `irq_ack` pulse removes exactly one record, and `cpl_slot`/`cpl_ts` then show the next one. An acknowledge while no record waits has no effect.
- R10: The command queue holds two commands. While the reader is busy with a frame, at most two further commands are accepted before `cmd_ready` drops to 0.
- R11: When the return queue is full (RET_DEPTH records), the reader finishes streaming the current frame. It then waits before writing the record and loses no record. The waiting record is stored after the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Slot memory byte write enable |
| mem_waddr | input | SLOT_W+BYTE_W | Write address, {slot, byte offset} |
| mem_wdata | input | 8 | Write data |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command queue has room |
| cmd_slot | input | SLOT_W | Slot to send |
| cmd_len | input | LEN_W | Frame length in bytes (0 means 1) |
| ts_in | input | TS_W | Free-running timestamp source |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| irq | output | 1 | Completion records pending (level) |
| irq_ack | input | 1 | Remove the oldest record |
| cpl_slot | output | SLOT_W | Slot index of the oldest record |
| cpl_ts | output | TS_W | Timestamp of the oldest record |

## Verification
A wrong byte index or slot base shows as a wrong `tx_data` value on the very byte it affects. A wrong length decode shows as a misplaced `tx_last` within the same frame. A corrupted return queue pointer or count is visible only when records are acknowledged. It shows as a repeated, skipped or stale `cpl_slot`/`cpl_ts`, or as `irq` staying high or dropping with the wrong number of records left. Stalls with `tx_ready` low expose a read port that advances without a handshake on the next cycle. A full queue with several frames waiting exposes a lost or duplicated completion.

// File: rtl/txr_pkg.sv
package txr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_SEND  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_END   = 3'd4
    } txr_state_e;
endpackage

// File: rtl/txr_fifo.sv
module txr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] store_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store_q[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + PW'(1);
        if (do_pop)  s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + PW'(1);
        if (do_push && !do_pop)      s_d.cnt = s_q.cnt + CW'(1);
        else if (do_pop && !do_push) s_d.cnt = s_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) store_q[s_q.wp] <= din;
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);
endmodule

// File: rtl/txr_slot_mem.sv
module txr_slot_mem #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/txr_reader_fsm.sv
module txr_reader_fsm
    import txr_pkg::*;
#(
    parameter int SLOT_W     = 1,
    parameter int BYTE_W     = 6,
    parameter int LEN_W      = 7,
    parameter int TS_W       = 32,
    parameter int SLOT_BYTES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_empty,
    input  logic [SLOT_W-1:0]        cmd_slot,
    input  logic [LEN_W-1:0]         cmd_len,
    output logic                     cmd_pop,
    output logic                     rd_en,
    output logic [SLOT_W+BYTE_W-1:0] rd_addr,
    output logic                     tx_valid,
    output logic                     tx_last,
    input  logic                     tx_ready,
    input  logic [TS_W-1:0]          ts_in,
    input  logic                     ret_full,
    output logic                     ret_push,
    output logic [SLOT_W-1:0]        ret_slot,
    output logic [TS_W-1:0]          ret_ts
);
    typedef struct packed {
        txr_state_e          st;
        logic [SLOT_W-1:0]   slot;
        logic [BYTE_W-1:0]   last_idx;
        logic [BYTE_W-1:0]   idx;
        logic [TS_W-1:0]     ts;
    } rd_st_t;

    rd_st_t s_d, s_q;
    logic [LEN_W-1:0] len_m1;
    logic             at_last;

    assign len_m1  = cmd_len - LEN_W'(1);
    assign at_last = (s_q.idx == s_q.last_idx);

    always_comb begin
        s_d      = s_q;
        cmd_pop  = 1'b0;
        rd_en    = 1'b0;
        rd_addr  = {s_q.slot, s_q.idx};
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        ret_push = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (!cmd_empty) begin
                    cmd_pop = 1'b1;
                    s_d.slot = cmd_slot;
                    if (cmd_len == '0)
                        s_d.last_idx = '0;
                    else if (cmd_len >= LEN_W'(SLOT_BYTES))
                        s_d.last_idx = BYTE_W'(SLOT_BYTES - 1);
                    else
                        s_d.last_idx = len_m1[BYTE_W-1:0];
                    s_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                rd_en   = 1'b1;
                rd_addr = {s_q.slot, {BYTE_W{1'b0}}};
                s_d.idx = '0;
                s_d.st  = ST_SEND;
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = at_last;
                if (tx_ready) begin
                    if (s_q.idx == '0) s_d.ts = ts_in;
                    if (at_last) begin
                        s_d.st = ret_full ? ST_HOLD : ST_END;
                    end else begin
                        rd_en   = 1'b1;
                        rd_addr = {s_q.slot, s_q.idx + BYTE_W'(1)};
                        s_d.idx = s_q.idx + BYTE_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (!ret_full) s_d.st = ST_END;
            end
            ST_END: begin
                ret_push = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    assign ret_slot = s_q.slot;
    assign ret_ts   = s_q.ts;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_end_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_END) |=> (s_q.st != ST_END));
    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (s_q.idx <= s_q.last_idx));
    assert_cmd_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pop |=> (s_q.st == ST_FETCH));
endmodule

// File: rtl/pktbuf_tx_reader.sv
module pktbuf_tx_reader #(
    parameter int NUM_SLOTS  = 2,
    parameter int SLOT_BYTES = 64,
    parameter int TS_EN      = 1,
    parameter int TS_W       = 32,
    parameter int RET_DEPTH  = 4,
    parameter int CMD_DEPTH  = 2,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BYTE_W    = $clog2(SLOT_BYTES),
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1),
    localparam int AW        = SLOT_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic [AW-1:0]     mem_waddr,
    input  logic [7:0]        mem_wdata,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [TS_W-1:0]   ts_in,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              irq,
    input  logic              irq_ack,
    output logic [SLOT_W-1:0] cpl_slot,
    output logic [TS_W-1:0]   cpl_ts
);
    localparam int CMD_W = SLOT_W + LEN_W;

    logic              cmd_full, cmd_empty, cmd_pop;
    logic [CMD_W-1:0]  cmd_head;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic              ret_full, ret_push;
    logic [SLOT_W-1:0] ret_slot;
    logic [TS_W-1:0]   ret_ts;

    assign cmd_ready = !cmd_full;

    txr_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_valid && !cmd_full), .din({cmd_slot, cmd_len}),
        .pop(cmd_pop), .dout(cmd_head),
        .full(cmd_full), .empty(cmd_empty)
    );

    txr_slot_mem #(.AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(rd_en), .raddr(rd_addr), .rdata(tx_data)
    );

    txr_reader_fsm #(
        .SLOT_W(SLOT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W),
        .TS_W(TS_W), .SLOT_BYTES(SLOT_BYTES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_empty(cmd_empty),
        .cmd_slot(cmd_head[CMD_W-1:LEN_W]), .cmd_len(cmd_head[LEN_W-1:0]),
        .cmd_pop(cmd_pop),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .ts_in(ts_in),
        .ret_full(ret_full), .ret_push(ret_push),
        .ret_slot(ret_slot), .ret_ts(ret_ts)
    );

    generate
        if (TS_EN != 0) begin : g_ret_fifo
            logic              ret_empty;
            logic [SLOT_W+TS_W-1:0] ret_head;
            txr_fifo #(.W(SLOT_W + TS_W), .DEPTH(RET_DEPTH)) u_ret_q (
                .clk(clk), .rst_n(rst_n),
                .push(ret_push), .din({ret_slot, ret_ts}),
                .pop(irq_ack && !ret_empty), .dout(ret_head),
                .full(ret_full), .empty(ret_empty)
            );
            assign irq      = !ret_empty;
            assign cpl_slot = ret_head[SLOT_W+TS_W-1:TS_W];
            assign cpl_ts   = ret_head[TS_W-1:0];
        end else begin : g_ret_reg
            typedef struct packed {
                logic              pend;
                logic [SLOT_W-1:0] slot;
            } pend_t;
            pend_t p_d, p_q;
            always_comb begin
                p_d = p_q;
                if (irq_ack) p_d.pend = 1'b0;
                if (ret_push) begin
                    p_d.pend = 1'b1;
                    p_d.slot = ret_slot;
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) p_q <= '0;
                else        p_q <= p_d;
            end
            assign ret_full = p_q.pend;
            assign irq      = p_q.pend;
            assign cpl_slot = p_q.slot;
            assign cpl_ts   = '0;
        end
    endgenerate

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    assert_gap_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);
    assert_irq_fall_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_ack));
endmodule

// File: tb/pktbuf_tx_reader_bench.sv
module pktbuf_tx_reader_bench;
    localparam int SB = 64;
    localparam int AW = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [0:0]  cmd_slot = '0;
    logic [6:0]  cmd_len = '0;
    logic [31:0] ts_in = '0;
    logic        tx_valid, tx_ready = 1'b0, tx_last;
    logic [7:0]  tx_data;
    logic        irq, irq_ack = 1'b0;
    logic [0:0]  cpl_slot;
    logic [31:0] cpl_ts;

    int n_chk = 0, n_bad = 0;
    int rdy_mode = 0;
    logic [7:0] img [128];
    int fq_slot[$], fq_len[$];
    int eq_slot[$];
    int eq_ts[$];
    int cur_idx = 0, cur_ts = 0, frames_seen = 0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic prev_last = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    pktbuf_tx_reader u_pktbuf_tx_reader (
        .clk(clk), .rst_n(rst_n),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_slot(cmd_slot), .cmd_len(cmd_len), .ts_in(ts_in),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .irq(irq), .irq_ack(irq_ack), .cpl_slot(cpl_slot), .cpl_ts(cpl_ts)
    );

    function automatic int eff_len(int len);
        if (len == 0) return 1;
        if (len > SB) return SB;
        return len;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stream monitor and stimulus for ready / timestamp
    initial begin
        forever begin
            @(negedge clk);
            ts_in = ts_in + 32'd7;
            case (rdy_mode)
                0: tx_ready = 1'b1;
                1: tx_ready = (($urandom % 4) != 0);
                default: tx_ready = 1'b0;
            endcase
            #1;
            if (prev_stall) begin
                chk(tx_valid == 1'b1, "R4 valid held", int'(tx_valid), 1);
                chk(tx_data == prev_data, "R4 data held", int'(tx_data), int'(prev_data));
                chk(tx_last == prev_last, "R4 last held", int'(tx_last), int'(prev_last));
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
            if (tx_valid && tx_ready) begin
                if (fq_slot.size() == 0) begin
                    chk(1'b0, "R6 unexpected byte", int'(tx_data), -1);
                end else begin
                    int s, l;
                    s = fq_slot[0];
                    l = fq_len[0];
                    if (cur_idx == 0) cur_ts = int'(ts_in);
                    chk(tx_data == img[s*SB + cur_idx], "R2 data",
                        int'(tx_data), int'(img[s*SB + cur_idx]));
                    chk(tx_last == (cur_idx == l - 1), "R3 last flag",
                        int'(tx_last), int'(cur_idx == l - 1));
                    if (cur_idx == l - 1) begin
                        eq_slot.push_back(s);
                        eq_ts.push_back(cur_ts);
                        void'(fq_slot.pop_front());
                        void'(fq_len.pop_front());
                        cur_idx = 0;
                        frames_seen++;
                    end else begin
                        cur_idx++;
                    end
                end
            end
        end
    end

    task automatic send_cmd(int slot, int len);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_slot  = 1'(slot);
        cmd_len   = 7'(len);
        #2;
        while (!cmd_ready) begin
            @(negedge clk);
            #2;
        end
        fq_slot.push_back(slot);
        fq_len.push_back(eff_len(len));
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (fq_slot.size() != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic ack_one();
        int es, et;
        @(negedge clk);
        #2;
        es = eq_slot[0];
        et = eq_ts[0];
        chk(irq == 1'b1, "R8 irq with record", int'(irq), 1);
        chk(int'(cpl_slot) == es, "R6 record slot", int'(cpl_slot), es);
        chk(int'(cpl_ts) == et, "R7 record timestamp", int'(cpl_ts), et);
        void'(eq_slot.pop_front());
        void'(eq_ts.pop_front());
        irq_ack = 1'b1;
        @(posedge clk);
        #1 irq_ack = 1'b0;
    endtask

    task automatic drain();
        while (eq_slot.size() != 0) begin
            ack_one();
            if (eq_slot.size() != 0) begin
                @(negedge clk);
                #2 chk(irq == 1'b1, "R8 irq stays with more records", int'(irq), 1);
            end
        end
        @(negedge clk);
        #2 chk(irq == 1'b0, "R8 irq low when empty", int'(irq), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int acc;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(tx_valid == 1'b0, "R1 tx_valid reset", int'(tx_valid), 0);
        chk(irq == 1'b0, "R1 irq reset", int'(irq), 0);
        chk(cmd_ready == 1'b1, "R1 cmd_ready reset", int'(cmd_ready), 1);

        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            mem_we    = 1'b1;
            mem_waddr = AW'(a);
            mem_wdata = 8'($urandom);
            img[a]    = mem_wdata;
        end
        @(negedge clk);
        mem_we = 1'b0;

        // R2/R3/R5 directed lengths
        rdy_mode = 0;
        send_cmd(0, 1);
        send_cmd(1, 0);   // R5 zero length
        send_cmd(0, 64);  // full slot
        send_cmd(1, 100); // R2 clamp
        wait_idle();
        chk(frames_seen == 4, "R6 frames sent", frames_seen, 4);
        drain();

        // R10 command queue depth while busy
        rdy_mode = 2;
        acc = 0;
        repeat (10) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_slot  = 1'b1;
            cmd_len   = 7'd5;
            #2;
            if (cmd_ready) begin
                acc++;
                fq_slot.push_back(1);
                fq_len.push_back(5);
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        #2;
        chk(acc == 3, "R10 commands accepted while busy", acc, 3);
        chk(cmd_ready == 1'b0, "R10 cmd_ready low when queue full", int'(cmd_ready), 0);
        rdy_mode = 1;
        wait_idle();
        drain();

        // R11 return queue full: five frames, no acknowledge
        frames_seen = 0;
        for (int i = 0; i < 5; i++) send_cmd(i % 2, 3 + i);
        wait_idle();
        chk(frames_seen == 5, "R11 fifth frame still streamed", frames_seen, 5);
        chk(irq == 1'b1, "R8 irq with full queue", int'(irq), 1);
        drain();

        // R9 acknowledge with nothing pending
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #2 chk(irq == 1'b0, "R9 empty ack ignored", int'(irq), 0);
        send_cmd(1, 9);
        wait_idle();
        drain();

        // random traffic
        for (int b = 0; b < 10; b++) begin
            int nf;
            nf = 1 + ($urandom % 4);
            for (int i = 0; i < nf; i++) send_cmd(int'($urandom % 2), int'($urandom % 71));
            wait_idle();
            drain();
        end

        done = 1;
        finish_run();
    end
endmodule